// File: doc/BRIEF.md
# DDR3 Mode Register 0 Load Command Encoder

This block turns a set of plain configuration inputs for a DDR3 memory device into the single command that loads mode register 0. The command is made up of the four active-low control strobes, the bank-address bits that select the register, and the row-address word that carries the fields. The inputs are the burst-length mode, the read burst ordering, the CAS latency in cycles, a DLL reset request, a test-mode bit, the precharge power-down exit choice, and two analog timings in picoseconds: the write-recovery time and the clock period.

The write-recovery field is derived, not supplied. The block takes the ceiling of write-recovery time over clock period. It then selects the smallest encodable cycle count that is not below that minimum. Encodable write-recovery values are 5, 6, 7, 8, 10, 12, 14 and 16 cycles. The encoding is irregular: 16 cycles wraps to code zero. The CAS latency code is split across non-adjacent address bits. A configuration error flag reports any setting that cannot be encoded.

A request is a valid/ready handshake on `start_valid`/`start_ready`, and it carries no payload beyond the configuration inputs sampled at acceptance. A request is accepted only on a cycle where both are high. A held request simply waits, with no loss, until ready returns. If the accepted request is legal, the command appears for exactly one cycle. A quiet period of `TMRD` cycles follows, during which ready stays low. A request accepted with an illegal configuration is consumed and dropped.

Top module: `mr0_cmd_encoder`

## Requirements
- R1: In the command cycle, `cmd_cs_n`, `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` are all 0, `cmd_ba` is 000, and `cmd_addr[14:13]` are 0. In every other cycle the four strobes are 1, `cmd_ba` is 000 and `cmd_addr` is 0.
- R2: `cmd_addr[1:0]` carries `bl_mode`. The code 00 means fixed eight-beat bursts, 01 means the length is picked per access, and 10 means fixed four-beat chop. The code 11 is reserved and raises `cfg_error`.
- R3: `cmd_addr[3]` equals `burst_interleave` (1 = interleaved ordering), `cmd_addr[7]` equals `test_mode`, `cmd_addr[8]` equals `dll_reset`, and `cmd_addr[12]` equals `pd_fast_exit` (1 = fast exit with DLL kept on).
- R4: For a CAS latency of 5 to 11 cycles, `cmd_addr[6:4]` is latency minus 4 and `cmd_addr[2]` is 0. For 12 to 16 cycles, `cmd_addr[6:4]` is latency minus 12 and `cmd_addr[2]` is 1. Any other latency raises `cfg_error`.
- R5: The write-recovery minimum is the ceiling of `twr_ps / tck_ps`. `cmd_addr[11:9]` takes the smallest value in {5,6,7,8,10,12,14,16} that is no smaller than this minimum. The codes are 001, 010, 011, 100, 101, 110, 111 for 5 through 14 cycles, and 000 for 16 cycles.
- R6: A write-recovery minimum above 16 cycles, or `tck_ps` equal to 0, raises `cfg_error`.
- R7: `cfg_error` follows the present configuration inputs combinationally, whether or not a request is pending.
- R8: A legal request accepted at a clock edge produces the command in the cycle that follows that edge, for exactly one cycle.
- R9: `start_ready` is low during the command cycle and during the `TMRD` cycles after it. A `start_valid` held through that period produces no command until ready returns. The request is then accepted, using the settings present at that time.
- R10: A request accepted while `cfg_error` is high produces no command, and `start_ready` stays high.
- R11: After reset, `start_ready` is high and the command outputs are at their idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request to issue the load command |
| start_ready | output | 1 | High when a request can be accepted |
| bl_mode | input | 2 | Burst-length mode |
| burst_interleave | input | 1 | Read burst ordering, 1 = interleaved |
| cas_lat | input | 5 | CAS latency in clock cycles |
| dll_reset | input | 1 | Request a DLL reset |
| test_mode | input | 1 | Test-mode bit |
| pd_fast_exit | input | 1 | Precharge power-down exit, 1 = fast |
| twr_ps | input | 16 | Write-recovery time in picoseconds |
| tck_ps | input | 16 | Clock period in picoseconds |
| cfg_error | output | 1 | Present configuration cannot be encoded |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 3 | Bank address, 000 selects this register |
| cmd_addr | output | 15 | Row-address word carrying the fields |

## Verification
Two events can collide in one cycle. The first is the end of the quiet period: the last busy cycle is followed by a ready cycle in which a request that was held valid throughout is accepted. The bench keeps `start_valid` high from the first command onward and changes the settings mid-way. It counts exactly `TMRD` not-ready cycles with the strobes idle, then expects a single second command carrying the new settings. The second collision is between an illegal setting and acceptance. In that case the bench presents a request while `cfg_error` is high and judges that no strobe falls and that ready never drops.

// File: rtl/mr0_pkg.sv
package mr0_pkg;

  localparam int ADDR_W = 15;
  localparam int BA_W   = 3;
  localparam int N_WR   = 8;

  // Field positions in the row-address word (decoded by the device)
  localparam int POS_BL   = 0;
  localparam int POS_CL0  = 2;
  localparam int POS_BT   = 3;
  localparam int POS_CLH  = 4;
  localparam int POS_TM   = 7;
  localparam int POS_DLL  = 8;
  localparam int POS_WR   = 9;
  localparam int POS_PD   = 12;

  typedef enum logic [1:0] {
    BLM_FIX8 = 2'b00,
    BLM_OTF  = 2'b01,
    BLM_FIX4 = 2'b10,
    BLM_RSVD = 2'b11
  } blm_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CMD  = 2'd1,
    SQ_BUSY = 2'd2
  } seq_state_e;

  // Ascending list of encodable write-recovery cycle counts
  function automatic logic [4:0] wr_step(input int idx);
    if (idx < 4) return 5'(5 + idx);
    else         return 5'(10 + 2 * (idx - 4));
  endfunction

  // Field code for list entry idx; the largest entry wraps to zero
  function automatic logic [2:0] wr_code(input int idx);
    if (idx == N_WR - 1) return 3'b000;
    else                 return 3'(idx + 1);
  endfunction

endpackage

// File: rtl/mr0_wr_encoder.sv
module mr0_wr_encoder
  import mr0_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic [TW-1:0] twr_ps,
  input  logic [TW-1:0] tck_ps,
  output logic [2:0]    wr_field,
  output logic          wr_err
);

  localparam int        QW  = TW + 1;
  localparam logic [QW-1:0] ONE = {{TW{1'b0}}, 1'b1};

  logic          tck_zero;
  logic [QW-1:0] divisor;
  logic [QW-1:0] numer;
  logic [QW-1:0] min_cyc;
  logic          found;
  logic [4:0]    pick_cyc;

  assign tck_zero = (tck_ps == '0);
  assign divisor  = tck_zero ? ONE : {1'b0, tck_ps};
  assign numer    = {1'b0, twr_ps} + divisor - ONE;
  assign min_cyc  = numer / divisor;

  always_comb begin
    found    = 1'b0;
    wr_field = 3'b000;
    pick_cyc = 5'd0;
    for (int i = 0; i < N_WR; i++) begin
      if (!found && ({{(QW-5){1'b0}}, wr_step(i)} >= min_cyc)) begin
        found    = 1'b1;
        wr_field = wr_code(i);
        pick_cyc = wr_step(i);
      end
    end
    wr_err = tck_zero || !found;
  end

  // R5: the chosen count covers the minimum, and the minimum is tight
  always_comb begin
    if (!wr_err) begin
      p_wr_covers_min_r5: assert ({{(QW-5){1'b0}}, pick_cyc} >= min_cyc);
      p_wr_min_tight_r5: assert (min_cyc * divisor >= {1'b0, twr_ps});
    end
  end

endmodule

// File: rtl/mr0_cl_encoder.sv
module mr0_cl_encoder
  import mr0_pkg::*;
(
  input  logic [4:0] cas_lat,
  input  logic [1:0] bl_mode,
  output logic [3:0] cl_code,
  output logic       cl_err,
  output logic       bl_err
);

  logic       lo_band;
  logic       hi_band;
  logic [4:0] lo_off;
  logic [4:0] hi_off;

  assign lo_band = (cas_lat >= 5'd5)  && (cas_lat <= 5'd11);
  assign hi_band = (cas_lat >= 5'd12) && (cas_lat <= 5'd16);
  assign lo_off  = cas_lat - 5'd4;
  assign hi_off  = cas_lat - 5'd12;

  // cl_code = {upper three bits, split low bit}
  always_comb begin
    if (hi_band)      cl_code = {hi_off[2:0], 1'b1};
    else if (lo_band) cl_code = {lo_off[2:0], 1'b0};
    else              cl_code = 4'b0000;
  end

  assign cl_err = !(lo_band || hi_band);
  assign bl_err = (blm_e'(bl_mode) == BLM_RSVD);

  // R4: a legal latency never yields the all-zero code
  always_comb begin
    if (!cl_err) p_cl_code_live_r4: assert (cl_code != 4'b0000);
  end

endmodule

// File: rtl/mr0_cmd_seq.sv
module mr0_cmd_seq
  import mr0_pkg::*;
#(
  parameter int TMRD = 4,
  parameter int AW   = ADDR_W,
  parameter int BW   = BA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic          cfg_err,
  input  logic [AW-1:0] addr_word,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [BW-1:0] ba,
  output logic [AW-1:0] addr
);

  localparam int CW = (TMRD < 2) ? 1 : $clog2(TMRD + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(TMRD - 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          accept;

  assign start_ready = (state == SQ_IDLE);
  assign accept      = start_valid && start_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      cs_n  <= 1'b1;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      ba    <= '0;
      addr  <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (accept && !cfg_err) begin
            state <= SQ_CMD;
            cs_n  <= 1'b0;
            ras_n <= 1'b0;
            cas_n <= 1'b0;
            we_n  <= 1'b0;
            ba    <= '0;
            addr  <= addr_word;
          end
        end
        SQ_CMD: begin
          state <= SQ_BUSY;
          cnt   <= CNT_LOAD;
          cs_n  <= 1'b1;
          ras_n <= 1'b1;
          cas_n <= 1'b1;
          we_n  <= 1'b1;
          addr  <= '0;
        end
        SQ_BUSY: begin
          if (cnt == '0) state <= SQ_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  p_cmd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> cs_n);

  p_cmd_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (!ras_n && !cas_n && !we_n && ba == '0 && addr[AW-1:AW-2] == 2'b00));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (ras_n && cas_n && we_n && ba == '0 && addr == '0));

  p_cmd_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !start_ready);

  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ready && cs_n) |=> cs_n);

  p_drop_bad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && cfg_err) |=> (cs_n && start_ready));

endmodule

// File: rtl/mr0_cmd_encoder.sv
module mr0_cmd_encoder
  import mr0_pkg::*;
#(
  parameter int TMRD = 4,
  parameter int TW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic [1:0]    bl_mode,
  input  logic          burst_interleave,
  input  logic [4:0]    cas_lat,
  input  logic          dll_reset,
  input  logic          test_mode,
  input  logic          pd_fast_exit,
  input  logic [TW-1:0] twr_ps,
  input  logic [TW-1:0] tck_ps,
  output logic          cfg_error,
  output logic          cmd_cs_n,
  output logic          cmd_ras_n,
  output logic          cmd_cas_n,
  output logic          cmd_we_n,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr
);

  logic [2:0]        wr_field;
  logic              wr_err;
  logic [3:0]        cl_code;
  logic              cl_err;
  logic              bl_err;
  logic [ADDR_W-1:0] word;

  mr0_wr_encoder #(.TW(TW)) u_wr (
    .twr_ps   (twr_ps),
    .tck_ps   (tck_ps),
    .wr_field (wr_field),
    .wr_err   (wr_err)
  );

  mr0_cl_encoder u_cl (
    .cas_lat (cas_lat),
    .bl_mode (bl_mode),
    .cl_code (cl_code),
    .cl_err  (cl_err),
    .bl_err  (bl_err)
  );

  always_comb begin
    word                     = '0;
    word[POS_BL +: 2]        = bl_mode;
    word[POS_CL0]            = cl_code[0];
    word[POS_BT]             = burst_interleave;
    word[POS_CLH +: 3]       = cl_code[3:1];
    word[POS_TM]             = test_mode;
    word[POS_DLL]            = dll_reset;
    word[POS_WR +: 3]        = wr_field;
    word[POS_PD]             = pd_fast_exit;
  end

  assign cfg_error = wr_err || cl_err || bl_err;

  mr0_cmd_seq #(.TMRD(TMRD), .AW(ADDR_W), .BW(BA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .cfg_err     (cfg_error),
    .addr_word   (word),
    .cs_n        (cmd_cs_n),
    .ras_n       (cmd_ras_n),
    .cas_n       (cmd_cas_n),
    .we_n        (cmd_we_n),
    .ba          (cmd_ba),
    .addr        (cmd_addr)
  );

endmodule

// File: tb/mr0_cmd_encoder_test.sv
`timescale 1ns/1ps
module mr0_cmd_encoder_test;

  localparam int TMRD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [1:0]  bl_mode = 2'b00;
  logic        burst_interleave = 1'b0;
  logic [4:0]  cas_lat = 5'd5;
  logic        dll_reset = 1'b0;
  logic        test_mode = 1'b0;
  logic        pd_fast_exit = 1'b0;
  logic [15:0] twr_ps = 16'd15000;
  logic [15:0] tck_ps = 16'd1250;
  logic        cfg_error;
  logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [2:0]  cmd_ba;
  logic [14:0] cmd_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mr0_cmd_encoder #(.TMRD(TMRD), .TW(16)) uut (
    .clk (clk), .rst_n (rst_n),
    .start_valid (start_valid), .start_ready (start_ready),
    .bl_mode (bl_mode), .burst_interleave (burst_interleave),
    .cas_lat (cas_lat), .dll_reset (dll_reset), .test_mode (test_mode),
    .pd_fast_exit (pd_fast_exit), .twr_ps (twr_ps), .tck_ps (tck_ps),
    .cfg_error (cfg_error),
    .cmd_cs_n (cmd_cs_n), .cmd_ras_n (cmd_ras_n), .cmd_cas_n (cmd_cas_n),
    .cmd_we_n (cmd_we_n), .cmd_ba (cmd_ba), .cmd_addr (cmd_addr)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected field word and error, built from the requirement text
  function automatic void model(input logic [1:0] bl, input logic bt,
      input int cl, input logic dll, input logic tm, input logic pd,
      input int twr, input int tck, output bit err, output int word);
    int steps[8] = '{5, 6, 7, 8, 10, 12, 14, 16};
    int codes[8] = '{1, 2, 3, 4, 5, 6, 7, 0};
    int m, wr, hi3, lo1;
    bit got;
    err = 1'b0; wr = 0; hi3 = 0; lo1 = 0; got = 1'b0;
    if (bl == 2'b11) err = 1'b1;
    if (cl >= 5 && cl <= 11) begin hi3 = cl - 4; lo1 = 0; end
    else if (cl >= 12 && cl <= 16) begin hi3 = cl - 12; lo1 = 1; end
    else err = 1'b1;
    if (tck == 0) err = 1'b1;
    else begin
      m = 0;
      while (m * tck < twr) m++;
      for (int i = 0; i < 8; i++)
        if (!got && steps[i] >= m) begin got = 1'b1; wr = codes[i]; end
      if (!got) err = 1'b1;
    end
    word = (int'(pd) << 12) | (wr << 9) | (int'(dll) << 8) | (int'(tm) << 7)
         | (hi3 << 4) | (int'(bt) << 3) | (lo1 << 2) | int'(bl);
  endfunction

  task automatic set_cfg(logic [1:0] bl, logic bt, int cl, logic dll,
      logic tm, logic pd, int twr, int tck);
    bl_mode = bl; burst_interleave = bt; cas_lat = 5'(cl);
    dll_reset = dll; test_mode = tm; pd_fast_exit = pd;
    twr_ps = 16'(twr); tck_ps = 16'(tck);
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 20 && !start_ready; k++) @(negedge clk);
  endtask

  // One request; checks either the command word or the drop
  task automatic run_case(string req, logic [1:0] bl, logic bt, int cl,
      logic dll, logic tm, logic pd, int twr, int tck);
    bit   e;
    int   w;
    model(bl, bt, cl, dll, tm, pd, twr, tck, e, w);
    wait_ready();
    set_cfg(bl, bt, cl, dll, tm, pd, twr, tck);
    start_valid = 1'b1;
    #1;
    chk(req, "cfg_error before accept", int'(cfg_error), int'(e));
    chk(req, "ready before accept", int'(start_ready), 1);
    @(negedge clk);
    start_valid = 1'b0;
    if (e) begin
      chk(req, "R10 no command on error", int'(cmd_cs_n), 1);
      chk(req, "R10 ready kept", int'(start_ready), 1);
    end else begin
      chk(req, "R1 strobes low", int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), 0);
      chk(req, "R1 bank", int'(cmd_ba), 0);
      chk(req, "address word", int'(cmd_addr), w);
      @(negedge clk);
      chk(req, "R8 single cycle", int'(cmd_cs_n), 1);
      chk(req, "R1 idle address", int'(cmd_addr), 0);
      wait_ready();
    end
  endtask

  task automatic t_reset();
    chk("R11", "ready after reset", int'(start_ready), 1);
    chk("R11", "strobes idle", int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), 15);
    chk("R11", "idle address", int'(cmd_addr), 0);
    chk("R11", "idle bank", int'(cmd_ba), 0);
  endtask

  task automatic t_fields();
    // R2 R4 R5: fixed BL8, CL5, 15000/1250 = 12 -> 12
    run_case("R2 R4 R5 case a", 2'b00, 1'b0, 5, 1'b0, 1'b0, 1'b0, 15000, 1250);
    // R3 R4: all single bits set, CL12 split bit, 15000/2500 = 6
    run_case("R3 R4 case b", 2'b01, 1'b1, 12, 1'b1, 1'b1, 1'b1, 15000, 2500);
    // R2 R4 R5: BC4, CL16, minimum 16 -> code 000
    run_case("R2 R4 R5 case c", 2'b10, 1'b0, 16, 1'b0, 1'b0, 1'b0, 15000, 938);
    // R5: exact division to 8, and one ps over to 9 -> 10
    run_case("R5 exact 8", 2'b00, 1'b1, 11, 1'b0, 1'b0, 1'b0, 15000, 1875);
    run_case("R5 round up to 10", 2'b00, 1'b0, 7, 1'b0, 1'b0, 1'b1, 15001, 1875);
    // R5: zero write recovery takes the smallest code
    run_case("R5 minimum five", 2'b01, 1'b0, 9, 1'b1, 1'b0, 1'b0, 0, 1500);
    // R6 boundary: exactly 16 legal
    run_case("R6 exactly sixteen", 2'b00, 1'b0, 13, 1'b0, 1'b0, 1'b0, 16000, 1000);
  endtask

  task automatic t_errors();
    run_case("R2 reserved burst", 2'b11, 1'b0, 6, 1'b0, 1'b0, 1'b0, 15000, 1250);
    run_case("R4 latency too low", 2'b00, 1'b0, 4, 1'b0, 1'b0, 1'b0, 15000, 1250);
    run_case("R4 latency too high", 2'b00, 1'b0, 17, 1'b0, 1'b0, 1'b0, 15000, 1250);
    run_case("R6 seventeen cycles", 2'b00, 1'b0, 8, 1'b0, 1'b0, 1'b0, 16001, 1000);
    run_case("R6 zero period", 2'b00, 1'b0, 8, 1'b0, 1'b0, 1'b0, 15000, 0);
  endtask

  task automatic t_comb_flag();
    // R7: flag follows inputs with no request
    wait_ready();
    set_cfg(2'b00, 1'b0, 8, 1'b0, 1'b0, 1'b0, 15000, 1250);
    #1 chk("R7", "flag clear", int'(cfg_error), 0);
    cas_lat = 5'd3;
    #1 chk("R7", "flag follows latency", int'(cfg_error), 1);
    cas_lat = 5'd8; bl_mode = 2'b11;
    #1 chk("R7", "flag follows burst mode", int'(cfg_error), 1);
    bl_mode = 2'b00;
    @(negedge clk);
    chk("R7", "no command without request", int'(cmd_cs_n), 1);
  endtask

  task automatic t_busy();
    bit e; int wa, wb; int busy_cnt;
    model(2'b00, 1'b0, 6, 1'b0, 1'b0, 1'b0, 15000, 1250, e, wa);
    model(2'b10, 1'b1, 14, 1'b1, 1'b0, 1'b1, 10000, 2500, e, wb);
    wait_ready();
    set_cfg(2'b00, 1'b0, 6, 1'b0, 1'b0, 1'b0, 15000, 1250);
    start_valid = 1'b1;
    @(negedge clk);
    chk("R8", "first command word", int'(cmd_addr), wa);
    chk("R9", "not ready in command cycle", int'(start_ready), 0);
    set_cfg(2'b10, 1'b1, 14, 1'b1, 1'b0, 1'b1, 10000, 2500);
    busy_cnt = 0;
    for (int k = 0; k < TMRD + 3; k++) begin
      @(negedge clk);
      if (start_ready) break;
      busy_cnt++;
      chk("R9", "no command while busy", int'(cmd_cs_n), 1);
    end
    chk("R9", "busy length", busy_cnt, TMRD);
    chk("R9", "ready again, idle strobes", int'(cmd_cs_n), 1);
    @(negedge clk);
    start_valid = 1'b0;
    chk("R9", "held request issued", int'(cmd_cs_n), 0);
    chk("R9", "held request uses new settings", int'(cmd_addr), wb);
    @(negedge clk);
    chk("R8", "held command single cycle", int'(cmd_cs_n), 1);
    wait_ready();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_errors();
    t_comb_flag();
    t_busy();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule